// File: doc/BRIEF.md
# Two-Way Instruction Cache with Word-Granular Validity

This block is a two-way set-associative instruction cache whose lines hold eight 32-bit words (32 bytes). Every word carries its own valid bit, so a line can be only partly present. This lets an external filler, such as a software decompression handler, write only the words from the missed one to the end of the line. A fetch is accepted when `fetch_req` and `fetch_ready` are both high. If the tag matches and the addressed word is valid, the word is returned on the next cycle.

Any other fetch parks the cache in a miss. The cache presents the line address and word offset of the miss and accepts single-word writes from the filler into the line it has chosen. It then waits for `fill_done` and repeats the lookup. Total capacity is set by `CACHE_BYTES`. A global invalidate pulse drops every valid bit in one cycle.

The controller has three states. READY takes new fetches. MISS holds the miss request and accepts fill writes. RETRY repeats the lookup for the parked address. The transitions are:
- READY to MISS on an accepted fetch that misses.
- MISS to RETRY on `fill_done`.
- RETRY to READY when the repeated lookup hits.
- RETRY to MISS when it misses again.

Top module: `icache_pwv`

## Requirements
- R1: Lines are 32 bytes (eight words) in two ways. The set count is CACHE_BYTES/64, for CACHE_BYTES from 1024 to 65536. The word offset is address bits [4:2], the set index starts at bit 5, and the tag is every bit above the index.
- R2: An accepted fetch whose tag matches a way holding at least one valid word, and whose addressed word is valid in that way, raises `fetch_valid` with that word on `fetch_data` in the next cycle and raises no miss.
- R3: Any other accepted fetch raises `miss_req` from the next cycle. `miss_line_addr` equals address bits [31:5] and `miss_word` equals bits [4:2]. Both stay stable while `miss_req` is high.
- R4: `fetch_ready` is low, and `fetch_valid` stays low, in the MISS and RETRY states.
- R5: While `miss_req` is high, `fill_we` writes `fill_data` into word `fill_word` of the chosen line and sets that word's valid bit. A `fill_we` at any other time changes nothing.
- R6: The cycle after `fill_done` is seen with `miss_req` high, the cache repeats the lookup with `miss_req` low. A hit then returns data one cycle later. A miss raises `miss_req` again.
- R7: Words of a line that were never written stay invalid. A fetch to one of them misses and refills the same line without reallocating it, so the other way of the set survives.
- R8: Allocating a new tag into a way clears all eight valid bits of that way before any fill write, so no word of the previous line can hit.
- R9: One LRU bit per set names the way to replace. It is set to the other way on every hit and every allocation. A line with no valid words never counts as a tag match.
- R10: `inv_all` clears every valid bit in one cycle. `fetch_ready` is low during that cycle.
- R11: After reset, `fetch_ready` is 1, `miss_req` and `fetch_valid` are 0, and every word is invalid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| inv_all | input | 1 | Drop all valid bits this cycle |
| fetch_req | input | 1 | Fetch request |
| fetch_addr | input | ADDR_W | Byte address of the fetched word |
| fetch_ready | output | 1 | Cache can accept a fetch this cycle |
| fetch_valid | output | 1 | Fetched word is on `fetch_data` |
| fetch_data | output | DATA_W | Fetched instruction word |
| miss_req | output | 1 | Miss outstanding, filler service wanted |
| miss_line_addr | output | ADDR_W-5 | Line address of the miss |
| miss_word | output | 3 | Word offset of the miss within its line |
| fill_we | input | 1 | Filler word write strobe |
| fill_word | input | 3 | Word offset of the filler write |
| fill_data | input | DATA_W | Word written by the filler |
| fill_done | input | 1 | Filler has finished the line |

## Verification
The bench leaves the leading words of a line unfilled and then fetches one of them. A design that tests only the tag would return stale or undefined data. A design that reallocates on that miss would evict the line in the other way, which a later fetch exposes as an unexpected miss. Next, a fully valid line is replaced by a line filled with one word only, and a neighbouring word of the new line is fetched. If allocation left the old valid bits in place, that fetch hits with the old line's data.

A filler that signals done without writing the missed word must cause a second miss request and not a false hit. A write strobe outside a miss must leave the stored data unchanged. The bench also walks the LRU victim order through hits and allocations, checks that the invalidate pulse stalls the fetch port, and checks that it forces misses on lines that were hitting just before.

// File: rtl/icache_pwv_pkg.sv
package icache_pwv_pkg;

    localparam int LINE_BYTES    = 32;
    localparam int WORD_BYTES    = 4;
    localparam int WORDS_PER_LN  = LINE_BYTES / WORD_BYTES;
    localparam int WORD_OFF_W    = $clog2(WORDS_PER_LN);
    localparam int LINE_OFF_W    = $clog2(LINE_BYTES);
    localparam int NUM_WAYS      = 2;

    typedef enum logic [1:0] {
        ST_READY = 2'd0,
        ST_MISS  = 2'd1,
        ST_RETRY = 2'd2
    } ic_state_e;

endpackage

// File: rtl/icache_pwv_tags.sv
module icache_pwv_tags
    import icache_pwv_pkg::*;
#(
    parameter int SETS  = 16,
    parameter int IDX_W = 4,
    parameter int TAG_W = 23
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  inv_all,
    input  logic [IDX_W-1:0]      lk_idx,
    input  logic [TAG_W-1:0]      lk_tag,
    input  logic [WORD_OFF_W-1:0] lk_word,
    output logic [NUM_WAYS-1:0]   hit_vec,
    output logic [NUM_WAYS-1:0]   match_vec,
    output logic                  lru_way,
    input  logic                  alloc_en,
    input  logic                  alloc_way,
    input  logic [IDX_W-1:0]      alloc_idx,
    input  logic [TAG_W-1:0]      alloc_tag,
    input  logic                  fill_en,
    input  logic                  fill_way,
    input  logic [IDX_W-1:0]      fill_idx,
    input  logic [WORD_OFF_W-1:0] fill_word,
    input  logic                  mru_en,
    input  logic                  mru_way,
    input  logic [IDX_W-1:0]      mru_idx
);

    // One tag array and one word-valid array per way
    for (genvar w = 0; w < NUM_WAYS; w++) begin : g_way
        logic [TAG_W-1:0]        tag_q [SETS];
        logic [WORDS_PER_LN-1:0] vld_q [SETS];
        logic                    sel_alloc;
        logic                    sel_fill;

        assign sel_alloc = alloc_en && (alloc_way == 1'(w));
        assign sel_fill  = fill_en  && (fill_way  == 1'(w));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                for (int s = 0; s < SETS; s++) begin
                    tag_q[s] <= '0;
                    vld_q[s] <= '0;
                end
            end else begin
                // The tag is written even during invalidate so the
                // chosen way always carries the pending tag.
                if (sel_alloc) begin
                    tag_q[alloc_idx] <= alloc_tag;
                end
                if (inv_all) begin
                    for (int s = 0; s < SETS; s++) begin
                        vld_q[s] <= '0;
                    end
                end else if (sel_alloc) begin
                    vld_q[alloc_idx] <= '0;
                end else if (sel_fill) begin
                    vld_q[fill_idx][fill_word] <= 1'b1;
                end
            end
        end

        // A line with no valid word is treated as absent
        assign match_vec[w] = (tag_q[lk_idx] == lk_tag) && (|vld_q[lk_idx]);
        assign hit_vec[w]   = match_vec[w] && vld_q[lk_idx][lk_word];
    end

    // Replacement bit per set: names the way to evict next
    logic [SETS-1:0] lru_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lru_q <= '0;
        end else if (mru_en) begin
            lru_q[mru_idx] <= ~mru_way;
        end
    end

    assign lru_way = lru_q[lk_idx];

endmodule

// File: rtl/icache_pwv_data.sv
module icache_pwv_data
    import icache_pwv_pkg::*;
#(
    parameter int SETS   = 16,
    parameter int IDX_W  = 4,
    parameter int DATA_W = 32
) (
    input  logic                             clk,
    input  logic [IDX_W-1:0]                 rd_idx,
    input  logic [WORD_OFF_W-1:0]            rd_word,
    output logic [NUM_WAYS-1:0][DATA_W-1:0]  rd_data,
    input  logic                             wr_en,
    input  logic                             wr_way,
    input  logic [IDX_W-1:0]                 wr_idx,
    input  logic [WORD_OFF_W-1:0]            wr_word,
    input  logic [DATA_W-1:0]                wr_data
);

    localparam int DEPTH = SETS * WORDS_PER_LN;

    for (genvar w = 0; w < NUM_WAYS; w++) begin : g_way
        logic [DATA_W-1:0] mem_q [DEPTH];

        always_ff @(posedge clk) begin
            if (wr_en && (wr_way == 1'(w))) begin
                mem_q[{wr_idx, wr_word}] <= wr_data;
            end
        end

        assign rd_data[w] = mem_q[{rd_idx, rd_word}];
    end

endmodule

// File: rtl/icache_pwv_ctrl.sv
module icache_pwv_ctrl
    import icache_pwv_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             inv_all,
    input  logic                             fetch_req,
    input  logic [ADDR_W-1:0]                fetch_addr,
    input  logic                             fill_done,
    input  logic [NUM_WAYS-1:0]              hit_vec,
    input  logic [NUM_WAYS-1:0]              match_vec,
    input  logic                             lru_way,
    input  logic [NUM_WAYS-1:0][DATA_W-1:0]  rd_data,
    output logic [ADDR_W-1:0]                lk_addr,
    output logic [ADDR_W-1:0]                pend_addr,
    output logic                             pend_way,
    output logic                             in_miss,
    output logic                             fetch_ready,
    output logic                             fetch_valid,
    output logic [DATA_W-1:0]                fetch_data,
    output logic                             alloc_en,
    output logic                             alloc_way,
    output logic                             mru_en,
    output logic                             mru_way
);

    ic_state_e state_q, state_d;

    logic look;
    logic hit_any;
    logic match_any;
    logic victim;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_READY;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_READY: begin
                if (look && !hit_any) begin
                    state_d = ST_MISS;
                end
            end
            ST_MISS: begin
                if (fill_done) begin
                    state_d = ST_RETRY;
                end
            end
            ST_RETRY: begin
                state_d = hit_any ? ST_READY : ST_MISS;
            end
            default: state_d = ST_READY;
        endcase
    end

    // Decoded outputs
    always_comb begin
        fetch_ready = 1'b0;
        in_miss     = 1'b0;
        look        = 1'b0;
        lk_addr     = fetch_addr;
        unique case (state_q)
            ST_READY: begin
                fetch_ready = !inv_all;
                look        = fetch_req && !inv_all;
            end
            ST_MISS: begin
                in_miss = 1'b1;
                lk_addr = pend_addr;
            end
            ST_RETRY: begin
                look    = 1'b1;
                lk_addr = pend_addr;
            end
            default: begin
                fetch_ready = 1'b0;
            end
        endcase

        hit_any   = |hit_vec;
        match_any = |match_vec;
        // Reuse the way that already holds the tag, else evict by LRU
        victim    = match_any ? match_vec[1] : lru_way;
        alloc_en  = look && !hit_any && !match_any;
        alloc_way = lru_way;
        mru_en    = look && (hit_any || !match_any);
        mru_way   = hit_any ? hit_vec[1] : lru_way;
    end

    // Response and pending-miss registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fetch_valid <= 1'b0;
            fetch_data  <= '0;
            pend_addr   <= '0;
            pend_way    <= 1'b0;
        end else begin
            fetch_valid <= look && hit_any;
            if (look && hit_any) begin
                fetch_data <= rd_data[hit_vec[1]];
            end
            if (look && !hit_any) begin
                pend_addr <= lk_addr;
                pend_way  <= victim;
            end
        end
    end

endmodule

// File: rtl/icache_pwv.sv
module icache_pwv
    import icache_pwv_pkg::*;
#(
    parameter int ADDR_W      = 32,
    parameter int DATA_W      = 32,
    parameter int CACHE_BYTES = 1024
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       inv_all,
    input  logic                       fetch_req,
    input  logic [ADDR_W-1:0]          fetch_addr,
    output logic                       fetch_ready,
    output logic                       fetch_valid,
    output logic [DATA_W-1:0]          fetch_data,
    output logic                       miss_req,
    output logic [ADDR_W-6:0]          miss_line_addr,
    output logic [2:0]                 miss_word,
    input  logic                       fill_we,
    input  logic [2:0]                 fill_word,
    input  logic [DATA_W-1:0]          fill_data,
    input  logic                       fill_done
);

    localparam int SETS   = CACHE_BYTES / (NUM_WAYS * LINE_BYTES);
    localparam int IDX_W  = $clog2(SETS);
    localparam int TAG_W  = ADDR_W - LINE_OFF_W - IDX_W;
    localparam int LINE_W = ADDR_W - LINE_OFF_W;

    logic [ADDR_W-1:0]               lk_addr;
    logic [ADDR_W-1:0]               pend_addr;
    logic                            pend_way;
    logic                            in_miss;
    logic [NUM_WAYS-1:0]             hit_vec;
    logic [NUM_WAYS-1:0]             match_vec;
    logic                            lru_way;
    logic [NUM_WAYS-1:0][DATA_W-1:0] rd_data;
    logic                            alloc_en;
    logic                            alloc_way;
    logic                            mru_en;
    logic                            mru_way;
    logic                            fill_en;
    logic [1:0]                      unused_byte_bits;

    logic [IDX_W-1:0]      lk_idx;
    logic [TAG_W-1:0]      lk_tag;
    logic [WORD_OFF_W-1:0] lk_word;
    logic [IDX_W-1:0]      pend_idx;

    assign lk_word  = lk_addr[LINE_OFF_W-1:2];
    assign lk_idx   = lk_addr[LINE_OFF_W +: IDX_W];
    assign lk_tag   = lk_addr[ADDR_W-1 -: TAG_W];
    assign pend_idx = pend_addr[LINE_OFF_W +: IDX_W];
    assign unused_byte_bits = lk_addr[1:0] ^ pend_addr[1:0];

    assign fill_en        = in_miss && fill_we;
    assign miss_req       = in_miss;
    assign miss_line_addr = pend_addr[ADDR_W-1 -: LINE_W];
    assign miss_word      = pend_addr[LINE_OFF_W-1:2];

    icache_pwv_ctrl #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .inv_all     (inv_all),
        .fetch_req   (fetch_req),
        .fetch_addr  (fetch_addr),
        .fill_done   (fill_done),
        .hit_vec     (hit_vec),
        .match_vec   (match_vec),
        .lru_way     (lru_way),
        .rd_data     (rd_data),
        .lk_addr     (lk_addr),
        .pend_addr   (pend_addr),
        .pend_way    (pend_way),
        .in_miss     (in_miss),
        .fetch_ready (fetch_ready),
        .fetch_valid (fetch_valid),
        .fetch_data  (fetch_data),
        .alloc_en    (alloc_en),
        .alloc_way   (alloc_way),
        .mru_en      (mru_en),
        .mru_way     (mru_way)
    );

    icache_pwv_tags #(
        .SETS  (SETS),
        .IDX_W (IDX_W),
        .TAG_W (TAG_W)
    ) u_tags (
        .clk       (clk),
        .rst_n     (rst_n),
        .inv_all   (inv_all),
        .lk_idx    (lk_idx),
        .lk_tag    (lk_tag),
        .lk_word   (lk_word),
        .hit_vec   (hit_vec),
        .match_vec (match_vec),
        .lru_way   (lru_way),
        .alloc_en  (alloc_en),
        .alloc_way (alloc_way),
        .alloc_idx (lk_idx),
        .alloc_tag (lk_tag),
        .fill_en   (fill_en),
        .fill_way  (pend_way),
        .fill_idx  (pend_idx),
        .fill_word (fill_word),
        .mru_en    (mru_en),
        .mru_way   (mru_way),
        .mru_idx   (lk_idx)
    );

    icache_pwv_data #(
        .SETS   (SETS),
        .IDX_W  (IDX_W),
        .DATA_W (DATA_W)
    ) u_data (
        .clk     (clk),
        .rd_idx  (lk_idx),
        .rd_word (lk_word),
        .rd_data (rd_data),
        .wr_en   (fill_en),
        .wr_way  (pend_way),
        .wr_idx  (pend_idx),
        .wr_word (fill_word),
        .wr_data (fill_data)
    );

endmodule

// File: rtl/icache_pwv_chk.sv
module icache_pwv_chk #(
    parameter int LINE_W = 27
) (
    input logic              clk,
    input logic              rst_n,
    input logic              inv_all,
    input logic              fetch_req,
    input logic              fetch_ready,
    input logic              fetch_valid,
    input logic              miss_req,
    input logic [LINE_W-1:0] miss_line_addr,
    input logic [2:0]        miss_word,
    input logic              fill_done,
    input logic [1:0]        match_vec
);

    AST_ACCEPT_RESOLVES: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_req && fetch_ready) |=> (fetch_valid || miss_req)); // R2

    AST_MISS_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (miss_req && $past(miss_req)) |-> ($stable(miss_line_addr) && $stable(miss_word))); // R3

    AST_MISS_STALLS: assert property (@(posedge clk) disable iff (!rst_n)
        miss_req |-> !fetch_ready); // R4

    AST_MISS_NO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        miss_req |-> !fetch_valid); // R4

    AST_DONE_RETRIES: assert property (@(posedge clk) disable iff (!rst_n)
        (miss_req && fill_done) |=> (!miss_req && !fetch_ready)); // R6

    AST_ONE_WAY_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(match_vec)); // R9

    AST_INV_STALLS: assert property (@(posedge clk) disable iff (!rst_n)
        inv_all |-> !fetch_ready); // R10

endmodule

bind icache_pwv icache_pwv_chk #(
    .LINE_W (ADDR_W - 5)
) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .inv_all        (inv_all),
    .fetch_req      (fetch_req),
    .fetch_ready    (fetch_ready),
    .fetch_valid    (fetch_valid),
    .miss_req       (miss_req),
    .miss_line_addr (miss_line_addr),
    .miss_word      (miss_word),
    .fill_done      (fill_done),
    .match_vec      (match_vec)
);

// File: tb/icache_pwv_tb_top.sv
`timescale 1ns/1ps
module icache_pwv_tb_top;

    localparam int ADDR_W = 32;
    localparam int DATA_W = 32;
    localparam int NVEC   = 13;

    // {expect_miss, byte address}; 1 KB default: set = addr[8:5], tag = addr[31:9]
    localparam logic [32:0] VEC [NVEC] = '{
        {1'b1, 32'h0000_0000},   // A w0 cold miss, full fill
        {1'b0, 32'h0000_001C},   // A w7 hit
        {1'b1, 32'h0000_0210},   // B w4 miss, fill 4..7 into other way
        {1'b0, 32'h0000_0214},   // B w5 hit
        {1'b1, 32'h0000_0204},   // B w1 partial-line miss, no realloc (R7)
        {1'b0, 32'h0000_0004},   // A still present (R7)
        {1'b1, 32'h0000_0200},   // B w0 still invalid (R7)
        {1'b1, 32'h0000_0400},   // C evicts LRU line A (R9)
        {1'b1, 32'h0000_0008},   // A evicts B (R9)
        {1'b0, 32'h0000_040C},   // C hit
        {1'b1, 32'h0000_0204},   // B evicts A
        {1'b1, 32'h0000_0420},   // other set (R1)
        {1'b0, 32'h0000_0420}    // hit in other set (R1)
    };

    logic              clk = 1'b0;
    logic              rst_n;
    logic              inv_all;
    logic              fetch_req;
    logic [ADDR_W-1:0] fetch_addr;
    logic              fetch_ready;
    logic              fetch_valid;
    logic [DATA_W-1:0] fetch_data;
    logic              miss_req;
    logic [ADDR_W-6:0] miss_line_addr;
    logic [2:0]        miss_word;
    logic              fill_we;
    logic [2:0]        fill_word;
    logic [DATA_W-1:0] fill_data;
    logic              fill_done;

    int checks    = 0;
    int failures  = 0;
    int fill_mode = 0;   // 0: missed word to end, 1: missed word only, 2: first service empty
    int serves    = 0;

    always #2 clk = ~clk;

    icache_pwv dut_i (
        .clk            (clk),
        .rst_n          (rst_n),
        .inv_all        (inv_all),
        .fetch_req      (fetch_req),
        .fetch_addr     (fetch_addr),
        .fetch_ready    (fetch_ready),
        .fetch_valid    (fetch_valid),
        .fetch_data     (fetch_data),
        .miss_req       (miss_req),
        .miss_line_addr (miss_line_addr),
        .miss_word      (miss_word),
        .fill_we        (fill_we),
        .fill_word      (fill_word),
        .fill_data      (fill_data),
        .fill_done      (fill_done)
    );

    function automatic logic [31:0] word_of(input logic [31:0] a);
        return {a[31:2], 2'b01} ^ 32'h5A5A_0000;
    endfunction

    task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", rq, act, exp);
        end
    endtask

    task automatic serve();
        logic [31:0] base;
        int first;
        int last;
        base  = {miss_line_addr, 5'b0};
        first = int'(miss_word);
        last  = (fill_mode == 1) ? first : 7;
        chk(!fetch_ready, "R4 ready low in miss", 32'(fetch_ready), 32'd0);
        serves++;
        if (!(fill_mode == 2 && serves == 1)) begin
            for (int w = first; w <= last; w++) begin
                fill_we   = 1'b1;
                fill_word = 3'(w);
                fill_data = word_of(base + 32'(4 * w));
                @(negedge clk);
            end
        end
        fill_we   = 1'b0;
        fill_done = 1'b1;
        @(negedge clk);
        fill_done = 1'b0;
    endtask

    task automatic do_fetch(input logic [31:0] a, input bit exp_miss, input string rq);
        int cyc;
        serves = 0;
        while (!fetch_ready) @(negedge clk);
        fetch_req  = 1'b1;
        fetch_addr = a;
        @(negedge clk);
        fetch_req = 1'b0;
        cyc = 0;
        while (!fetch_valid && cyc < 100) begin
            if (miss_req) begin
                chk(miss_line_addr == a[31:5], {rq, " R3 line"}, 32'(miss_line_addr), 32'(a[31:5]));
                chk(miss_word == a[4:2], {rq, " R3 word"}, 32'(miss_word), 32'(a[4:2]));
                serve();
            end else begin
                @(negedge clk);
                cyc++;
            end
        end
        chk(fetch_valid, {rq, " R6 response"}, 32'(fetch_valid), 32'd1);
        chk((serves != 0) == exp_miss, {rq, " hit/miss"}, 32'(serves), 32'(exp_miss));
        chk(fetch_data == word_of(a), {rq, " data"}, fetch_data, word_of(a));
        @(negedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        rst_n      = 1'b0;
        inv_all    = 1'b0;
        fetch_req  = 1'b0;
        fetch_addr = '0;
        fill_we    = 1'b0;
        fill_word  = '0;
        fill_data  = '0;
        fill_done  = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R11 reset state
        chk(fetch_ready == 1'b1, "R11 ready", 32'(fetch_ready), 32'd1);
        chk(miss_req == 1'b0, "R11 miss_req", 32'(miss_req), 32'd0);
        chk(fetch_valid == 1'b0, "R11 valid", 32'(fetch_valid), 32'd0);

        // Table walk: R2 hits, R3 misses, R7 partial lines, R9 LRU order, R1 mapping
        for (int i = 0; i < NVEC; i++) begin
            do_fetch(VEC[i][31:0], VEC[i][32], VEC[i][32] ? "R3 table miss" : "R2 table hit");
        end

        // R10 global invalidate stalls and drops a hitting line
        inv_all = 1'b1;
        #1;
        chk(fetch_ready == 1'b0, "R10 stall during invalidate", 32'(fetch_ready), 32'd0);
        @(negedge clk);
        inv_all = 1'b0;
        do_fetch(32'h0000_040C, 1'b1, "R10 line dropped");

        // R8: allocation over a full line clears its valid bits
        do_fetch(32'h0000_0600, 1'b1, "R9 allocate");
        fill_mode = 1;
        do_fetch(32'h0000_080C, 1'b1, "R9 allocate single word");
        do_fetch(32'h0000_0A04, 1'b1, "R8 replace full line");
        do_fetch(32'h0000_0A08, 1'b1, "R8 stale word must miss");
        do_fetch(32'h0000_080C, 1'b0, "R9 recently used line kept");

        // R6: done without writing the missed word gives a second miss
        fill_mode = 2;
        do_fetch(32'h0000_0C10, 1'b1, "R6 empty fill");
        chk(serves == 2, "R6 second miss request", 32'(serves), 32'd2);
        fill_mode = 0;

        // R5: a fill strobe with no miss outstanding changes nothing
        fill_we   = 1'b1;
        fill_word = 3'd4;
        fill_data = 32'hDEAD_BEEF;
        @(negedge clk);
        fill_we = 1'b0;
        do_fetch(32'h0000_0C10, 1'b0, "R5 idle write ignored");

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule